// File: doc/BRIEF.md
# Multi-Port Command Crossbar Arbiter

This block lets several independent requesters share one storage controller. Every side speaks the same packet interface. The command direction carries strobe, start-of-packet, end-of-packet, acknowledge, a set of command qualifiers and a data word. The response direction carries the same framing plus response flags and read data.

When the block is idle it picks one requesting port by round-robin. It then connects that port's command stream straight to the controller and returns the controller's response stream only to that port. Ports that lose arbitration are stalled: their acknowledge and response strobe stay low, so they keep presenting their command unchanged until they win.

The grant is locked for the whole transaction. It covers every command packet and write-data beat, and it ends only when the controller's response beat flagged last completes its end-of-packet handshake. The port number never appears on any interface. The block needs no extra fields to route responses, because only one transaction is ever in flight.

Top module: `cmd_xbar`

## Requirements
- R1: While rst_ni is low, every command acknowledge toward the ports, every response strobe toward the ports, the controller command strobe and the controller response acknowledge are 0.
- R2: When no transaction is held, the block grants the requesting port (usr_cmd_stb_i bit set) with the lowest index above the last granted index, wrapping from NPORTS-1 to 0. After reset, the search starts as if port NPORTS-1 had been granted last.
- R3: A port whose strobe is seen high at a clock edge while the block is idle, and that wins, is granted from the next cycle. While it is granted, its strobe, sop, eop, write, read, identify, sector, count and data appear unchanged on the controller command outputs, and ctl_cmd_ack_i is returned on its usr_cmd_ack_o bit.
- R4: A port that is not granted sees usr_cmd_ack_o and usr_rsp_stb_o at 0. While nothing is granted, ctl_cmd_stb_o is 0.
- R5: Response beats (stb, sop, eop, write, read, identify, last, failed, data) reach only the granted port, and ctl_rsp_ack_o equals that port's usr_rsp_ack_i.
- R6: The grant does not change across any number of command packets or response beats until the release handshake. Commands from other ports are never forwarded in between.
- R7: The release handshake is a controller response beat with stb, ack, eop and last all 1. In the cycle after it, no port is granted. A new grant becomes visible one cycle later.
- R8: A response beat with last=1 but eop=0 does not release the grant.
- R9: While no port is granted, ctl_rsp_ack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usr_cmd_stb_i | input | NPORTS | Command beat valid, one bit per port |
| usr_cmd_sop_i | input | NPORTS | Command start of packet |
| usr_cmd_eop_i | input | NPORTS | Command end of packet |
| usr_cmd_write_i | input | NPORTS | Write command qualifier |
| usr_cmd_read_i | input | NPORTS | Read command qualifier |
| usr_cmd_ident_i | input | NPORTS | Identify command qualifier |
| usr_cmd_sector_i | input | NPORTS*48 | Start sector, 48 bits per port |
| usr_cmd_count_i | input | NPORTS*16 | Sector count, 16 bits per port |
| usr_cmd_data_i | input | NPORTS*DATA_W | Write data per port |
| usr_cmd_ack_o | output | NPORTS | Command beat accepted |
| usr_rsp_stb_o | output | NPORTS | Response beat valid |
| usr_rsp_sop_o | output | NPORTS | Response start of packet |
| usr_rsp_eop_o | output | NPORTS | Response end of packet |
| usr_rsp_write_o | output | NPORTS | Response belongs to a write |
| usr_rsp_read_o | output | NPORTS | Response belongs to a read |
| usr_rsp_ident_o | output | NPORTS | Response belongs to an identify |
| usr_rsp_last_o | output | NPORTS | Final response packet of the transaction |
| usr_rsp_failed_o | output | NPORTS | Error reported by the controller |
| usr_rsp_data_o | output | NPORTS*DATA_W | Read data per port |
| usr_rsp_ack_i | input | NPORTS | Response beat taken by the port |
| ctl_cmd_stb_o | output | 1 | Command beat valid toward controller |
| ctl_cmd_sop_o | output | 1 | Command start of packet |
| ctl_cmd_eop_o | output | 1 | Command end of packet |
| ctl_cmd_write_o | output | 1 | Write qualifier |
| ctl_cmd_read_o | output | 1 | Read qualifier |
| ctl_cmd_ident_o | output | 1 | Identify qualifier |
| ctl_cmd_sector_o | output | 48 | Start sector |
| ctl_cmd_count_o | output | 16 | Sector count |
| ctl_cmd_data_o | output | DATA_W | Write data |
| ctl_cmd_ack_i | input | 1 | Controller accepted the command beat |
| ctl_rsp_stb_i | input | 1 | Response beat valid from controller |
| ctl_rsp_sop_i | input | 1 | Response start of packet |
| ctl_rsp_eop_i | input | 1 | Response end of packet |
| ctl_rsp_write_i | input | 1 | Response write flag |
| ctl_rsp_read_i | input | 1 | Response read flag |
| ctl_rsp_ident_i | input | 1 | Response identify flag |
| ctl_rsp_last_i | input | 1 | Final response packet flag |
| ctl_rsp_failed_i | input | 1 | Error flag |
| ctl_rsp_data_i | input | DATA_W | Read data |
| ctl_rsp_ack_o | output | 1 | Response beat taken by the granted port |

## Verification
A grant that is lost or moved early shows up within a cycle. The controller then receives a command whose sector tag names a port other than the owner, or the issuing port receives a response strobe that the bench did not expect. A release that comes too late leaves every other requester stalled, which the bench's stall limit catches. A wrong round-robin pointer shows up at the next arbitration, as a command from the wrong port on the controller side.

// File: rtl/cmd_xbar_pkg.sv
package cmd_xbar_pkg;
  localparam int SECTOR_W = 48;
  localparam int COUNT_W  = 16;

  typedef struct packed {
    logic                wr;
    logic                rd;
    logic                ident;
    logic [SECTOR_W-1:0] sector;
    logic [COUNT_W-1:0]  count;
  } cmd_hdr_t;
endpackage

// File: rtl/cmd_xbar_arb.sv
module cmd_xbar_arb #(
  parameter int NPORTS = 4,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPORTS-1:0] req_i,
  input  logic              release_i,
  output logic              busy_o,
  output logic [NPORTS-1:0] gnt_oh_o,
  output logic [IDX_W-1:0]  gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q, pick;
  logic             found;

  // round-robin search starting after the last winner
  always_comb begin
    pick  = ptr_q;
    found = 1'b0;
    for (int k = 1; k <= NPORTS; k++) begin
      int unsigned cand;
      cand = (int'(ptr_q) + k) % NPORTS;
      if (!found && req_i[cand]) begin
        pick  = IDX_W'(cand);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      gnt_idx_o <= '0;
      ptr_q     <= IDX_W'(NPORTS - 1);
    end else if (busy_o) begin
      if (release_i) busy_o <= 1'b0;
    end else if (found) begin
      busy_o    <= 1'b1;
      gnt_idx_o <= pick;
      ptr_q     <= pick;
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_oh
    assign gnt_oh_o[g] = busy_o && (gnt_idx_o == IDX_W'(g));
  end

  // R3
  grant_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && |req_i) |=> busy_o);
  // R6
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !release_i) |=> (busy_o && $stable(gnt_idx_o)));
  // R7
  grant_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && release_i) |=> !busy_o);
endmodule

// File: rtl/cmd_xbar_cmd_mux.sv
module cmd_xbar_cmd_mux
  import cmd_xbar_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPORTS-1:0]          gnt_oh_i,
  input  logic [NPORTS-1:0]          stb_i,
  input  logic [NPORTS-1:0]          sop_i,
  input  logic [NPORTS-1:0]          eop_i,
  input  logic [NPORTS-1:0]          wr_i,
  input  logic [NPORTS-1:0]          rd_i,
  input  logic [NPORTS-1:0]          ident_i,
  input  logic [NPORTS*SECTOR_W-1:0] sector_i,
  input  logic [NPORTS*COUNT_W-1:0]  count_i,
  input  logic [NPORTS*DATA_W-1:0]   data_i,
  output logic [NPORTS-1:0]          ack_o,
  output logic                       stb_o,
  output logic                       sop_o,
  output logic                       eop_o,
  output cmd_hdr_t                   hdr_o,
  output logic [DATA_W-1:0]          data_o,
  input  logic                       ack_i
);
  // AND-OR mux on the one-hot grant
  always_comb begin
    stb_o  = 1'b0;
    sop_o  = 1'b0;
    eop_o  = 1'b0;
    hdr_o  = '0;
    data_o = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (gnt_oh_i[i]) begin
        stb_o        |= stb_i[i];
        sop_o        |= sop_i[i];
        eop_o        |= eop_i[i];
        hdr_o.wr     |= wr_i[i];
        hdr_o.rd     |= rd_i[i];
        hdr_o.ident  |= ident_i[i];
        hdr_o.sector |= sector_i[i*SECTOR_W +: SECTOR_W];
        hdr_o.count  |= count_i[i*COUNT_W +: COUNT_W];
        data_o       |= data_i[i*DATA_W +: DATA_W];
      end
    end
  end

  assign ack_o = gnt_oh_i & {NPORTS{ack_i}};

  // R4
  cmd_ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));
endmodule

// File: rtl/cmd_xbar_rsp_demux.sv
module cmd_xbar_rsp_demux #(
  parameter int NPORTS = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NPORTS-1:0]        gnt_oh_i,
  input  logic                     stb_i,
  input  logic                     sop_i,
  input  logic                     eop_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic                     ident_i,
  input  logic                     last_i,
  input  logic                     failed_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic                     ack_o,
  output logic [NPORTS-1:0]        stb_o,
  output logic [NPORTS-1:0]        sop_o,
  output logic [NPORTS-1:0]        eop_o,
  output logic [NPORTS-1:0]        wr_o,
  output logic [NPORTS-1:0]        rd_o,
  output logic [NPORTS-1:0]        ident_o,
  output logic [NPORTS-1:0]        last_o,
  output logic [NPORTS-1:0]        failed_o,
  output logic [NPORTS*DATA_W-1:0] data_o,
  input  logic [NPORTS-1:0]        ack_i
);
  // payload is broadcast; only the strobe is steered
  assign stb_o    = gnt_oh_i & {NPORTS{stb_i}};
  assign sop_o    = {NPORTS{sop_i}};
  assign eop_o    = {NPORTS{eop_i}};
  assign wr_o     = {NPORTS{wr_i}};
  assign rd_o     = {NPORTS{rd_i}};
  assign ident_o  = {NPORTS{ident_i}};
  assign last_o   = {NPORTS{last_i}};
  assign failed_o = {NPORTS{failed_i}};
  assign data_o   = {NPORTS{data_i}};
  assign ack_o    = |(gnt_oh_i & ack_i);

  // R5
  rsp_stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));
endmodule

// File: rtl/cmd_xbar.sv
module cmd_xbar
  import cmd_xbar_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPORTS-1:0]          usr_cmd_stb_i,
  input  logic [NPORTS-1:0]          usr_cmd_sop_i,
  input  logic [NPORTS-1:0]          usr_cmd_eop_i,
  input  logic [NPORTS-1:0]          usr_cmd_write_i,
  input  logic [NPORTS-1:0]          usr_cmd_read_i,
  input  logic [NPORTS-1:0]          usr_cmd_ident_i,
  input  logic [NPORTS*48-1:0]       usr_cmd_sector_i,
  input  logic [NPORTS*16-1:0]       usr_cmd_count_i,
  input  logic [NPORTS*DATA_W-1:0]   usr_cmd_data_i,
  output logic [NPORTS-1:0]          usr_cmd_ack_o,
  output logic [NPORTS-1:0]          usr_rsp_stb_o,
  output logic [NPORTS-1:0]          usr_rsp_sop_o,
  output logic [NPORTS-1:0]          usr_rsp_eop_o,
  output logic [NPORTS-1:0]          usr_rsp_write_o,
  output logic [NPORTS-1:0]          usr_rsp_read_o,
  output logic [NPORTS-1:0]          usr_rsp_ident_o,
  output logic [NPORTS-1:0]          usr_rsp_last_o,
  output logic [NPORTS-1:0]          usr_rsp_failed_o,
  output logic [NPORTS*DATA_W-1:0]   usr_rsp_data_o,
  input  logic [NPORTS-1:0]          usr_rsp_ack_i,
  output logic                       ctl_cmd_stb_o,
  output logic                       ctl_cmd_sop_o,
  output logic                       ctl_cmd_eop_o,
  output logic                       ctl_cmd_write_o,
  output logic                       ctl_cmd_read_o,
  output logic                       ctl_cmd_ident_o,
  output logic [47:0]                ctl_cmd_sector_o,
  output logic [15:0]                ctl_cmd_count_o,
  output logic [DATA_W-1:0]          ctl_cmd_data_o,
  input  logic                       ctl_cmd_ack_i,
  input  logic                       ctl_rsp_stb_i,
  input  logic                       ctl_rsp_sop_i,
  input  logic                       ctl_rsp_eop_i,
  input  logic                       ctl_rsp_write_i,
  input  logic                       ctl_rsp_read_i,
  input  logic                       ctl_rsp_ident_i,
  input  logic                       ctl_rsp_last_i,
  input  logic                       ctl_rsp_failed_i,
  input  logic [DATA_W-1:0]          ctl_rsp_data_i,
  output logic                       ctl_rsp_ack_o
);
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic              busy;
  logic [NPORTS-1:0] gnt_oh;
  logic [IDX_W-1:0]  gnt_idx;
  logic              rel;
  cmd_hdr_t          hdr;

  // transaction ends on the accepted final beat of the last packet
  assign rel = ctl_rsp_stb_i && ctl_rsp_ack_o && ctl_rsp_eop_i && ctl_rsp_last_i;

  cmd_xbar_arb #(.NPORTS(NPORTS)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(usr_cmd_stb_i), .release_i(rel),
    .busy_o(busy), .gnt_oh_o(gnt_oh), .gnt_idx_o(gnt_idx)
  );

  cmd_xbar_cmd_mux #(.NPORTS(NPORTS), .DATA_W(DATA_W)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .gnt_oh_i(gnt_oh),
    .stb_i(usr_cmd_stb_i), .sop_i(usr_cmd_sop_i), .eop_i(usr_cmd_eop_i),
    .wr_i(usr_cmd_write_i), .rd_i(usr_cmd_read_i), .ident_i(usr_cmd_ident_i),
    .sector_i(usr_cmd_sector_i), .count_i(usr_cmd_count_i), .data_i(usr_cmd_data_i),
    .ack_o(usr_cmd_ack_o), .stb_o(ctl_cmd_stb_o), .sop_o(ctl_cmd_sop_o),
    .eop_o(ctl_cmd_eop_o), .hdr_o(hdr), .data_o(ctl_cmd_data_o), .ack_i(ctl_cmd_ack_i)
  );

  assign ctl_cmd_write_o  = hdr.wr;
  assign ctl_cmd_read_o   = hdr.rd;
  assign ctl_cmd_ident_o  = hdr.ident;
  assign ctl_cmd_sector_o = hdr.sector;
  assign ctl_cmd_count_o  = hdr.count;

  cmd_xbar_rsp_demux #(.NPORTS(NPORTS), .DATA_W(DATA_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .gnt_oh_i(gnt_oh),
    .stb_i(ctl_rsp_stb_i), .sop_i(ctl_rsp_sop_i), .eop_i(ctl_rsp_eop_i),
    .wr_i(ctl_rsp_write_i), .rd_i(ctl_rsp_read_i), .ident_i(ctl_rsp_ident_i),
    .last_i(ctl_rsp_last_i), .failed_i(ctl_rsp_failed_i), .data_i(ctl_rsp_data_i),
    .ack_o(ctl_rsp_ack_o), .stb_o(usr_rsp_stb_o), .sop_o(usr_rsp_sop_o),
    .eop_o(usr_rsp_eop_o), .wr_o(usr_rsp_write_o), .rd_o(usr_rsp_read_o),
    .ident_o(usr_rsp_ident_o), .last_o(usr_rsp_last_o), .failed_o(usr_rsp_failed_o),
    .data_o(usr_rsp_data_o), .ack_i(usr_rsp_ack_i)
  );

  // R9
  idle_rsp_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !ctl_rsp_ack_o);
  // R4
  idle_cmd_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !ctl_cmd_stb_o);
  // R8
  partial_last_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rsp_stb_i && ctl_rsp_ack_o && ctl_rsp_last_i && !ctl_rsp_eop_i) |=>
      (busy && $stable(gnt_idx)));
endmodule

// File: tb/sim_cmd_xbar.sv
module sim_cmd_xbar;
  localparam int N  = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] u_cstb, u_csop, u_ceop, u_cwr, u_crd, u_cid, u_cack;
  logic [N*48-1:0] u_sec;
  logic [N*16-1:0] u_cnt;
  logic [N*DW-1:0] u_cdat, u_rdat;
  logic [N-1:0] u_rstb, u_rsop, u_reop, u_rwr, u_rrd, u_rid, u_rlast, u_rfail, u_rack;
  logic c_cstb, c_csop, c_ceop, c_cwr, c_crd, c_cid, c_cack;
  logic [47:0] c_sec;
  logic [15:0] c_cnt;
  logic [DW-1:0] c_cdat, c_rdat;
  logic c_rstb, c_rsop, c_reop, c_rwr, c_rrd, c_rid, c_rlast, c_rfail, c_rack;

  cmd_xbar #(.NPORTS(N), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .usr_cmd_stb_i(u_cstb), .usr_cmd_sop_i(u_csop), .usr_cmd_eop_i(u_ceop),
    .usr_cmd_write_i(u_cwr), .usr_cmd_read_i(u_crd), .usr_cmd_ident_i(u_cid),
    .usr_cmd_sector_i(u_sec), .usr_cmd_count_i(u_cnt), .usr_cmd_data_i(u_cdat),
    .usr_cmd_ack_o(u_cack),
    .usr_rsp_stb_o(u_rstb), .usr_rsp_sop_o(u_rsop), .usr_rsp_eop_o(u_reop),
    .usr_rsp_write_o(u_rwr), .usr_rsp_read_o(u_rrd), .usr_rsp_ident_o(u_rid),
    .usr_rsp_last_o(u_rlast), .usr_rsp_failed_o(u_rfail), .usr_rsp_data_o(u_rdat),
    .usr_rsp_ack_i(u_rack),
    .ctl_cmd_stb_o(c_cstb), .ctl_cmd_sop_o(c_csop), .ctl_cmd_eop_o(c_ceop),
    .ctl_cmd_write_o(c_cwr), .ctl_cmd_read_o(c_crd), .ctl_cmd_ident_o(c_cid),
    .ctl_cmd_sector_o(c_sec), .ctl_cmd_count_o(c_cnt), .ctl_cmd_data_o(c_cdat),
    .ctl_cmd_ack_i(c_cack),
    .ctl_rsp_stb_i(c_rstb), .ctl_rsp_sop_i(c_rsop), .ctl_rsp_eop_i(c_reop),
    .ctl_rsp_write_i(c_rwr), .ctl_rsp_read_i(c_rrd), .ctl_rsp_ident_i(c_rid),
    .ctl_rsp_last_i(c_rlast), .ctl_rsp_failed_i(c_rfail), .ctl_rsp_data_i(c_rdat),
    .ctl_rsp_ack_o(c_rack)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] cmd_word(int p, int s, int b);
    return {8'(p), 8'(s), 16'(b)};
  endfunction

  // round-robin reference
  function automatic int rr_pick(logic [N-1:0] req, int ptr);
    for (int k = 1; k <= N; k++) if (req[(ptr + k) % N]) return (ptr + k) % N;
    return -1;
  endfunction

  // user models: 0 idle, 1 sending, 2 waiting for response
  int us[N], ub[N], unb[N], urd[N], useq[N], ucnt[N], udone[N];
  // controller model
  int cport, crd, ccnt, rn, ri;
  bit rsop[8], reop[8], rlast[8];
  // arbiter reference
  int ebusy, egnt, eptr;
  // recorded handshakes of the previous cycle
  logic [N-1:0] h_req, h_ucf, h_urf;
  bit h_ccf, h_ccf_eop, h_crf, h_rel, h_part;
  int stall;

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    u_cstb = '1; u_csop = '0; u_ceop = '0; u_cwr = '0; u_crd = '0; u_cid = '0;
    u_sec = '0; u_cnt = '0; u_cdat = '0; u_rack = '1;
    c_cack = 1'b1; c_rstb = 1'b1; c_rsop = 1'b0; c_reop = 1'b1; c_rwr = 1'b0;
    c_rrd = 1'b0; c_rid = 1'b0; c_rlast = 1'b1; c_rfail = 1'b0; c_rdat = '0;
    for (int i = 0; i < N; i++) begin
      us[i] = 0; ub[i] = 0; unb[i] = 1; urd[i] = 0; useq[i] = 0; ucnt[i] = 1; udone[i] = 0;
    end
    rn = 0; ri = 0; cport = 0; crd = 0; ccnt = 0;
    ebusy = 0; egnt = 0; eptr = N - 1;
    h_req = '0; h_ucf = '0; h_urf = '0;
    h_ccf = 0; h_ccf_eop = 0; h_crf = 0; h_rel = 0; h_part = 0; stall = 0;

    repeat (3) @(negedge clk);
    // R1: reset holds everything quiet even with inputs active
    chk(u_cack == '0, "R1 cmd ack", longint'(u_cack), 0);
    chk(u_rstb == '0, "R1 rsp stb", longint'(u_rstb), 0);
    chk(c_cstb == 1'b0, "R1 ctl cmd stb", longint'(c_cstb), 0);
    chk(c_rack == 1'b0, "R1 ctl rsp ack", longint'(c_rack), 0);
    u_cstb = '0; c_rstb = 1'b0; c_cack = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 30000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      // ---- apply the handshakes of the last edge to the models
      if (ebusy != 0) begin
        if (h_rel) ebusy = 0;
      end else begin
        int p;
        p = rr_pick(h_req, eptr);
        if (p >= 0) begin ebusy = 1; egnt = p; eptr = p; end
      end
      for (int i = 0; i < N; i++) begin
        if (h_ucf[i]) begin
          ub[i]++;
          if (ub[i] == unb[i]) us[i] = 2;
        end
        if (h_urf[i] && h_rel) begin us[i] = 0; udone[i]++; stall = 0; end
      end
      if (h_crf) begin
        ri++;
        if (ri == rn) begin rn = 0; ri = 0; end
      end
      if (h_ccf && h_ccf_eop) begin
        // build the response: read data packet then a two-beat last packet
        rn = 0;
        if (crd != 0) begin
          for (int b = 0; b < ccnt; b++) begin
            rsop[rn] = (b == 0); reop[rn] = (b == ccnt - 1); rlast[rn] = 0; rn++;
          end
          rsop[rn] = 1; reop[rn] = 0; rlast[rn] = 1; rn++;
          rsop[rn] = 0; reop[rn] = 1; rlast[rn] = 1; rn++;
        end else begin
          rsop[rn] = 1; reop[rn] = 1; rlast[rn] = 1; rn++;
        end
        ri = 0;
      end
      // ---- new stimulus
      for (int i = 0; i < N; i++) begin
        if (us[i] == 0 && (cyc == 0 || ($urandom % 100) < 30)) begin
          us[i] = 1; ub[i] = 0; useq[i]++;
          urd[i] = int'($urandom % 2);
          unb[i] = (urd[i] != 0) ? 1 : 1 + int'($urandom % 3);
          ucnt[i] = 1 + int'($urandom % 3);
        end
        u_cstb[i] = (us[i] == 1);
        u_csop[i] = (ub[i] == 0);
        u_ceop[i] = (ub[i] == unb[i] - 1);
        u_cwr[i]  = (urd[i] == 0);
        u_crd[i]  = (urd[i] != 0);
        u_cid[i]  = 1'b0;
        u_sec[i*48 +: 48] = {40'(useq[i]), 8'(i)};
        u_cnt[i*16 +: 16] = 16'((urd[i] != 0) ? ucnt[i] : unb[i]);
        u_cdat[i*DW +: DW] = cmd_word(i, useq[i], ub[i]);
        u_rack[i] = (($urandom % 100) < 75);
      end
      c_cack = (rn == 0) && (($urandom % 100) < 70);
      c_rstb = (rn != 0);
      c_rsop = rsop[ri]; c_reop = reop[ri]; c_rlast = rlast[ri];
      c_rwr = (crd == 0); c_rrd = (crd != 0); c_rid = 1'b0; c_rfail = 1'b0;
      c_rdat = {8'(cport), 8'hA5, 16'(ri)};
      #1;
      // ---- checks
      if (h_rel) chk(c_cstb == 1'b0, "R7 idle after release", longint'(c_cstb), 0);
      if (h_part) chk(c_rack == u_rack[egnt] && ebusy != 0, "R8 partial last keeps grant",
                      longint'(c_rack), longint'(u_rack[egnt]));
      begin
        bit es;
        es = (ebusy != 0) && (us[egnt] == 1);
        chk(c_cstb == es, (ebusy != 0) ? "R3 ctl cmd stb" : "R4 ctl cmd stb idle",
            longint'(c_cstb), longint'(es));
        if (c_cstb && es) begin
          chk(c_sec[7:0] == 8'(egnt), "R2 R6 winner port", longint'(c_sec[7:0]), egnt);
          chk(c_cdat == cmd_word(egnt, useq[egnt], ub[egnt]) && c_csop == (ub[egnt] == 0)
              && c_ceop == (ub[egnt] == unb[egnt] - 1) && c_crd == (urd[egnt] != 0),
              "R3 cmd payload", longint'(c_cdat), longint'(cmd_word(egnt, useq[egnt], ub[egnt])));
        end
      end
      for (int i = 0; i < N; i++) begin
        bit own, ea, er;
        own = (ebusy != 0) && (i == egnt);
        ea = own && c_cack;
        er = own && (rn != 0);
        chk(u_cack[i] == ea, own ? "R3 cmd ack" : "R4 cmd ack", longint'(u_cack[i]), longint'(ea));
        chk(u_rstb[i] == er, own ? "R5 rsp stb" : "R4 rsp stb", longint'(u_rstb[i]), longint'(er));
        if (er && u_rstb[i])
          chk(u_rdat[i*DW +: DW] == c_rdat && u_rdat[i*DW+24 +: 8] == 8'(i)
              && u_rlast[i] == c_rlast && u_reop[i] == c_reop && u_rrd[i] == c_rrd,
              "R5 rsp payload", longint'(u_rdat[i*DW +: DW]), longint'(c_rdat));
      end
      begin
        bit eack;
        eack = (ebusy != 0) && u_rack[egnt];
        chk(c_rack == eack, (ebusy != 0) ? "R5 ctl rsp ack" : "R9 ctl rsp ack idle",
            longint'(c_rack), longint'(eack));
      end
      // ---- record handshakes for the next edge
      h_req = u_cstb;
      h_ucf = u_cstb & u_cack;
      h_urf = u_rstb & u_rack;
      h_ccf = c_cstb && c_cack;
      h_ccf_eop = c_ceop;
      if (h_ccf) begin cport = int'(c_sec[7:0]); crd = int'(c_crd); ccnt = int'(c_cnt); end
      h_crf = c_rstb && c_rack;
      h_rel = h_crf && c_reop && c_rlast;
      h_part = h_crf && !c_reop && c_rlast;
      stall++;
      if (stall > 3000) begin
        chk(1'b0, "watchdog R7 no progress", stall, 0);
        break;
      end
    end
    for (int i = 0; i < N; i++)
      chk(udone[i] > 10, "R2 every port served", udone[i], 11);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule